// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds three outgoing CAN frames and chooses which of them the bit-level transmitter sends next. Software fills a mailbox through a small write port. It writes a length word, two words of payload bytes, and then an identifier word whose bit 0 requests transmission. A one-bit rule input selects the ordering among pending mailboxes. With the rule at 0, the frame with the numerically lowest identifier goes first. With the rule at 1, the frame whose request arrived earliest goes first.

The chosen frame is offered on a valid/ready stream. `tx_valid` rises once a frame has been chosen. It stays high, with every payload field held unchanged, until the cycle in which `tx_ready` is sampled high. After that handshake the transmitter reports exactly one outcome through a one-cycle `res_valid` strobe, and no further frame is offered until that outcome arrives. The strobe is always accepted, so the result path has no back-pressure. A 32-bit status word reports per-mailbox completion and outcome flags, empty flags, an index of a free mailbox, and which pending mailbox would be sent last. Writing ones to that word clears completion flags and cancels requests.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every mailbox is empty, no flag is set, `tx_valid` is low and `sts` reads 0x1C000000.
- R2: The identifier word holds the request at bit 0, remote select at bit 1, extended select at bit 2, the extended identifier at [20:3] and the standard identifier at [31:21]. Writes of any kind to a mailbox that is pending or in flight are ignored.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_mbx`, `tx_id`, `tx_len` and `tx_data` stay unchanged. `tx_id` is the stored identifier word with bit 0 set. `tx_len` is the stored length limited to 8. `tx_data` carries byte 0 in bits [7:0]. The result codes are 0 for success, 1 for lost arbitration, and 2 or 3 for error.
- R4: With `order_sel`=0, the pending mailbox with the smallest key goes first. The key is bits [31:21] followed by bits [20:3] when bit 2 is set, or by zeros when bit 2 is clear. Equal keys go to the lower mailbox number.
- R5: With `order_sel`=1, the pending mailbox whose request was set earliest goes first.
- R6: A success result sets the mailbox's complete flag (bit 8k) and success flag (bit 8k+1) and leaves the mailbox empty.
- R7: Lost arbitration sets bit 8k+2 and an error result sets bit 8k+3. In both cases the mailbox becomes pending again with its complete flag clear.
- R8: With `no_retry` high, a failed attempt is not repeated. The mailbox completes with its success flag clear and its lost or error flag set.
- R9: Writing 1 to bit 8k+7 of `sts_wdata` while mailbox k is pending and not in flight empties it, sets its complete flag and clears its success flag.
- R10: A cancel of a mailbox in flight, including one written in the same cycle as the result, takes effect only if the attempt fails. The mailbox then completes without retry. A success outcome overrides the cancel.
- R11: Writing 1 to bit 8k clears the complete, success, lost and error flags of mailbox k. A completion in the same cycle wins over the clear.
- R12: Bits 26+k show that mailbox k is empty. Bits [25:24] give the lowest-numbered empty mailbox, or 3 when none is empty.
- R13: With two or more mailboxes pending and not in flight, bit 29+k marks the one that the active rule would send last. Otherwise bits [31:29] are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_sel | input | 1 | 0: lowest key first, 1: earliest request first |
| no_retry | input | 1 | Failed attempts complete instead of retrying |
| cfg_we | input | 1 | Mailbox write strobe |
| cfg_mbx | input | 2 | Mailbox number for the write |
| cfg_reg | input | 2 | 0 identifier word, 1 length in [3:0], 2 bytes 0-3, 3 bytes 4-7 |
| cfg_wdata | input | 32 | Mailbox write data |
| sts_we | input | 1 | Status write strobe (write-one actions) |
| sts_wdata | input | 32 | Status write data |
| sts | output | 32 | Status word |
| tx_valid | output | 1 | A frame is offered |
| tx_ready | input | 1 | Transmitter takes the offered frame |
| tx_mbx | output | 2 | Mailbox of the offered frame |
| tx_id | output | 32 | Identifier word of the offered frame |
| tx_len | output | 4 | Byte count, 0 to 8 |
| tx_data | output | 64 | Payload bytes |
| res_valid | input | 1 | One-cycle outcome strobe for the frame in flight |
| res_code | input | 2 | Outcome code |

## Verification
Cancellation and the end of an attempt are the two functions that can land in the same cycle. The bench drives a cancel write on the same clock edge that a lost-arbitration result arrives. It judges the outcome by the mailbox completing with the lost flag set and never being offered again. A second collision pairs a complete-flag clear with a success completion, and the complete flag must survive. Ordering is provoked by keeping one frame in flight while the other mailboxes are loaded, so that every candidate is pending at the moment the choice is made.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int NMBX   = 3;
  localparam int IDXW   = 2;
  localparam int WORDW  = 32;
  localparam int KEYW   = 29;
  localparam int EXTW   = 18;
  localparam int DLCW   = 4;
  localparam int MAXLEN = 8;
  localparam int DATAW  = 64;
  localparam int STRIDE = 8;
  localparam int EMPTY_LSB = 26;
  localparam int LOWP_LSB  = 29;
  localparam int FREE_LSB  = 24;

  typedef enum logic [1:0] {RES_OK = 2'd0, RES_LOST = 2'd1, RES_ERR = 2'd2} res_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_OFFER = 2'd1, ST_WAIT = 2'd2} ctl_e;

  typedef struct packed {
    logic terr;
    logic alst;
    logic ok;
    logic cmp;
  } mflags_t;

  function automatic logic [KEYW-1:0] id_key(input logic [WORDW-1:0] w);
    return {w[31:21], (w[2] ? w[20:3] : {EXTW{1'b0}})};
  endfunction
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_id,
  input  logic             ld_len,
  input  logic             ld_dlo,
  input  logic             ld_dhi,
  input  logic [WORDW-1:0] wdata,
  input  logic             cancel,
  input  logic             clr,
  input  logic             launch,
  input  logic             res_v,
  input  logic [1:0]       res_code,
  input  logic             no_retry,
  output logic [WORDW-1:0] id_word,
  output logic [DLCW-1:0]  len,
  output logic [DATAW-1:0] data,
  output logic             pend,
  output logic             busy,
  output logic             empty,
  output logic             req_set,
  output mflags_t          flags
);
  logic [WORDW-1:1] id_q;
  logic             cxl_q;

  assign empty   = !pend && !busy;
  assign req_set = ld_id && empty && wdata[0];
  assign id_word = {id_q, pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      len   <= '0;
      data  <= '0;
      pend  <= 1'b0;
      busy  <= 1'b0;
      cxl_q <= 1'b0;
      flags <= '0;
    end else begin
      if (clr) flags <= '0;
      if (ld_id && empty) begin
        id_q <= wdata[WORDW-1:1];
        if (wdata[0]) begin
          pend  <= 1'b1;
          flags <= '0;
        end
      end
      if (ld_len && empty) len <= wdata[DLCW-1:0];
      if (ld_dlo && empty) data[31:0]  <= wdata;
      if (ld_dhi && empty) data[63:32] <= wdata;
      if (launch) begin
        pend  <= 1'b0;
        busy  <= 1'b1;
        cxl_q <= 1'b0;
      end
      if (cancel) begin
        if (busy || launch) cxl_q <= 1'b1;
        else if (pend) begin
          pend      <= 1'b0;
          flags.cmp <= 1'b1;
          flags.ok  <= 1'b0;
        end
      end
      if (busy && res_v) begin
        busy  <= 1'b0;
        cxl_q <= 1'b0;
        if (res_code == RES_OK) begin
          flags.cmp <= 1'b1;
          flags.ok  <= 1'b1;
        end else begin
          if (res_code == RES_LOST) flags.alst <= 1'b1;
          else                      flags.terr <= 1'b1;
          if (no_retry || cxl_q || cancel) begin
            flags.cmp <= 1'b1;
            flags.ok  <= 1'b0;
          end else begin
            pend <= 1'b1;
          end
        end
      end
    end
  end

  p_ok_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_v && res_code == RES_OK) |=> (flags.cmp && flags.ok && empty));

  p_noretry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_v && res_code != RES_OK && no_retry) |=> (empty && flags.cmp && !flags.ok));

  p_cancel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !launch && cancel) |=> (empty && flags.cmp && !flags.ok));

  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_v && res_code != RES_OK && !no_retry && !cxl_q && !cancel) |=> (pend && !flags.cmp));
endmodule

// File: rtl/can_txmb_age.sv
module can_txmb_age
  import can_txmb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NMBX-1:0]            req_set,
  output logic [NMBX-1:0][NMBX-1:0]  older
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMBX; i++)
        for (int j = 0; j < NMBX; j++)
          older[i][j] <= (i < j);
    end else begin
      for (int i = 0; i < NMBX; i++) begin
        if (req_set[i]) begin
          for (int j = 0; j < NMBX; j++) begin
            if (j != i) begin
              older[i][j] <= 1'b0;
              older[j][i] <= 1'b1;
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NMBX; i++) begin : g_row
    for (genvar j = i + 1; j < NMBX; j++) begin : g_col
      p_age_antisym_r5: assert property (@(posedge clk) disable iff (!rst_n)
        older[i][j] != older[j][i]);
    end
  end
endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick
  import can_txmb_pkg::*;
(
  input  logic [NMBX-1:0]             pend,
  input  logic [NMBX-1:0][WORDW-1:0]  id_words,
  input  logic [NMBX-1:0][NMBX-1:0]   older,
  input  logic                        order_sel,
  output logic                        has_pick,
  output logic [IDXW-1:0]             pick_idx,
  output logic [NMBX-1:0]             low_flag
);
  logic [NMBX-1:0][KEYW-1:0] key;
  logic [NMBX-1:0][NMBX-1:0] beats;
  logic [NMBX-1:0]           win;
  logic [NMBX-1:0]           lose;
  logic [IDXW:0]             npend;

  always_comb begin
    for (int i = 0; i < NMBX; i++) key[i] = id_key(id_words[i]);
    for (int i = 0; i < NMBX; i++) begin
      for (int j = 0; j < NMBX; j++) begin
        if (i == j)         beats[i][j] = 1'b0;
        else if (order_sel) beats[i][j] = older[i][j];
        else                beats[i][j] = (key[i] < key[j]) || ((key[i] == key[j]) && (i < j));
      end
    end
  end

  always_comb begin
    npend = '0;
    for (int i = 0; i < NMBX; i++) begin
      win[i]  = pend[i];
      lose[i] = pend[i];
      npend   = npend + {{IDXW{1'b0}}, pend[i]};
      for (int j = 0; j < NMBX; j++) begin
        if (j != i && pend[j]) begin
          win[i]  = win[i] & beats[i][j];
          lose[i] = lose[i] & beats[j][i];
        end
      end
    end
    has_pick = |win;
    pick_idx = '0;
    for (int i = NMBX - 1; i >= 0; i--)
      if (win[i]) pick_idx = IDXW'(i);
    low_flag = (npend >= 2) ? lose : '0;
  end
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
  import can_txmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        order_sel,
  input  logic        no_retry,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_mbx,
  input  logic [1:0]  cfg_reg,
  input  logic [31:0] cfg_wdata,
  input  logic        sts_we,
  input  logic [31:0] sts_wdata,
  output logic [31:0] sts,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [1:0]  tx_mbx,
  output logic [31:0] tx_id,
  output logic [3:0]  tx_len,
  output logic [63:0] tx_data,
  input  logic        res_valid,
  input  logic [1:0]  res_code
);
  localparam logic [IDXW-1:0] NONE_IDX = IDXW'(NMBX);

  logic [NMBX-1:0][WORDW-1:0] id_words;
  logic [NMBX-1:0][DLCW-1:0]  lens;
  logic [NMBX-1:0][DATAW-1:0] datas;
  logic [NMBX-1:0]            pend, busy, empty, req_set, launch, res_v;
  logic [NMBX-1:0]            low_flag;
  mflags_t [NMBX-1:0]         flags;
  logic [NMBX-1:0][NMBX-1:0]  older;
  logic                       has_pick;
  logic [IDXW-1:0]            pick_idx, cur_q, free_idx;
  ctl_e                       st_q;

  for (genvar k = 0; k < NMBX; k++) begin : g_mbx
    logic sel;
    assign sel       = cfg_we && (cfg_mbx == IDXW'(k));
    assign launch[k] = (st_q == ST_IDLE) && has_pick && (pick_idx == IDXW'(k));
    assign res_v[k]  = (st_q == ST_WAIT) && res_valid && (cur_q == IDXW'(k));

    can_txmb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_id    (sel && cfg_reg == 2'd0),
      .ld_len   (sel && cfg_reg == 2'd1),
      .ld_dlo   (sel && cfg_reg == 2'd2),
      .ld_dhi   (sel && cfg_reg == 2'd3),
      .wdata    (cfg_wdata),
      .cancel   (sts_we && sts_wdata[STRIDE*k+7]),
      .clr      (sts_we && sts_wdata[STRIDE*k]),
      .launch   (launch[k]),
      .res_v    (res_v[k]),
      .res_code (res_code),
      .no_retry (no_retry),
      .id_word  (id_words[k]),
      .len      (lens[k]),
      .data     (datas[k]),
      .pend     (pend[k]),
      .busy     (busy[k]),
      .empty    (empty[k]),
      .req_set  (req_set[k]),
      .flags    (flags[k])
    );
  end

  can_txmb_age u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_set (req_set),
    .older   (older)
  );

  can_txmb_pick u_pick (
    .pend      (pend),
    .id_words  (id_words),
    .older     (older),
    .order_sel (order_sel),
    .has_pick  (has_pick),
    .pick_idx  (pick_idx),
    .low_flag  (low_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (has_pick) begin st_q <= ST_OFFER; cur_q <= pick_idx; end
        ST_OFFER: if (tx_ready) st_q <= ST_WAIT;
        ST_WAIT:  if (res_valid) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    free_idx = NONE_IDX;
    for (int k = NMBX - 1; k >= 0; k--)
      if (empty[k]) free_idx = IDXW'(k);
  end

  always_comb begin
    sts = '0;
    for (int k = 0; k < NMBX; k++) begin
      sts[STRIDE*k +: 4]   = flags[k];
      sts[EMPTY_LSB + k]   = empty[k];
      sts[LOWP_LSB + k]    = low_flag[k];
    end
    sts[FREE_LSB +: IDXW] = free_idx;
  end

  assign tx_valid = (st_q == ST_OFFER);
  assign tx_mbx   = cur_q;
  assign tx_id    = {id_words[cur_q][WORDW-1:1], 1'b1};
  assign tx_len   = (lens[cur_q] > DLCW'(MAXLEN)) ? DLCW'(MAXLEN) : lens[cur_q];
  assign tx_data  = datas[cur_q];

  p_one_busy_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(busy));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_mbx) && $stable(tx_id) && $stable(tx_data)));

  p_offer_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy[cur_q]);

  p_free_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (free_idx != NONE_IDX) |-> empty[free_idx]);

  p_low_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(low_flag) && ((low_flag & ~pend) == '0));
endmodule

// File: tb/can_txmb_sched_tb.sv
module can_txmb_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        order_sel = 1'b0, no_retry = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mbx = '0, cfg_reg = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sts_we = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic [31:0] sts;
  logic        tx_valid, tx_ready = 1'b0;
  logic [1:0]  tx_mbx;
  logic [31:0] tx_id;
  logic [3:0]  tx_len;
  logic [63:0] tx_data;
  logic        res_valid = 1'b0;
  logic [1:0]  res_code = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_txmb_sched u_dut (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .no_retry(no_retry),
    .cfg_we(cfg_we), .cfg_mbx(cfg_mbx), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts(sts),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_mbx(tx_mbx), .tx_id(tx_id),
    .tx_len(tx_len), .tx_data(tx_data), .res_valid(res_valid), .res_code(res_code)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [1:0] r, input logic [31:0] d);
    cfg_we = 1'b1; cfg_mbx = m; cfg_reg = r; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wsts(input logic [31:0] d);
    sts_we = 1'b1; sts_wdata = d;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = '0;
  endtask

  task automatic load(input logic [1:0] m, input logic [31:0] idw, input logic [3:0] len,
                      input logic [31:0] lo, input logic [31:0] hi);
    wr(m, 2'd1, {28'd0, len});
    wr(m, 2'd2, lo);
    wr(m, 2'd3, hi);
    wr(m, 2'd0, idw | 32'd1);
  endtask

  task automatic wait_offer(input logic [1:0] m, input string tag);
    for (int c = 0; c < 20 && !tx_valid; c++) @(negedge clk);
    chk({tag, " offer"}, tx_valid, 1);
    chk({tag, " mailbox"}, tx_mbx, m);
  endtask

  task automatic accept();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic result(input logic [1:0] c);
    res_valid = 1'b1; res_code = c;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic send(input logic [1:0] m, input logic [1:0] c, input string tag);
    wait_offer(m, tag);
    accept();
    result(c);
  endtask

  task automatic quiet(input string tag);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(tag, tx_valid, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 status", sts, 32'h1C00_0000);
    chk("R1 valid", tx_valid, 0);
  endtask

  task automatic t_basic();
    load(2'd0, 32'h2460_0000, 4'd4, 32'h4433_2211, 32'h8877_6655);
    wait_offer(2'd0, "R3");
    chk("R3 id", tx_id, 32'h2460_0001);
    chk("R3 len", tx_len, 4);
    chk("R3 data", tx_data, 64'h8877_6655_4433_2211);
    chk("R12 free", sts[25:24], 1);
    chk("R12 empty0", sts[26], 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R3 hold", {tx_valid, tx_mbx}, {1'b1, 2'd0});
      chk("R3 hold id", tx_id, 32'h2460_0001);
    end
    wr(2'd0, 2'd0, 32'h1110_0001);
    wr(2'd0, 2'd1, 32'd2);
    chk("R2 id ignored", tx_id, 32'h2460_0001);
    chk("R2 len ignored", tx_len, 4);
    accept();
    result(2'd0);
    chk("R6 flags", sts[3:0], 4'b0011);
    chk("R6 empty", sts[26], 1);
    wsts(32'h0000_0001);
    chk("R11 clear", sts[3:0], 4'b0000);
    chk("R12 free back", sts[25:24], 0);
  endtask

  task automatic t_len();
    load(2'd1, 32'h0020_0000, 4'd12, 32'd0, 32'd0);
    wait_offer(2'd1, "R3 sat");
    chk("R3 len saturate", tx_len, 8);
    accept();
    result(2'd0);
    wsts(32'h0000_0100);
  endtask

  task automatic t_idorder();
    order_sel = 1'b0;
    load(2'd0, 32'h6000_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd0, "R4 first");
    accept();
    load(2'd1, 32'h2000_002C, 4'd1, 32'd0, 32'd0);
    load(2'd2, 32'h2000_0FF8, 4'd1, 32'd0, 32'd0);
    chk("R12 none free", sts[25:24], 3);
    chk("R12 none empty", sts[28:26], 3'b000);
    result(2'd1);
    chk("R7 lost flag", sts[3:0], 4'b0100);
    chk("R13 low id", sts[31:29], 3'b001);
    send(2'd2, 2'd0, "R4 std before ext");
    send(2'd1, 2'd0, "R4 ext");
    send(2'd0, 2'd0, "R7 retried");
    wsts(32'h0001_0101);
    load(2'd0, 32'h8000_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd0, "R4 tie lead");
    accept();
    load(2'd2, 32'h0A00_0000, 4'd1, 32'd0, 32'd0);
    load(2'd1, 32'h0A00_0000, 4'd1, 32'd0, 32'd0);
    result(2'd0);
    send(2'd1, 2'd0, "R4 tie lower");
    send(2'd2, 2'd0, "R4 tie upper");
    wsts(32'h0001_0101);
    chk("R11 all clear", sts, 32'h1C00_0000);
  endtask

  task automatic t_ageorder();
    order_sel = 1'b1;
    load(2'd0, 32'h8000_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd0, "R5 lead");
    accept();
    load(2'd2, 32'hFFE0_0000, 4'd1, 32'd0, 32'd0);
    load(2'd1, 32'h0020_0000, 4'd1, 32'd0, 32'd0);
    result(2'd0);
    chk("R13 low age", sts[31:29], 3'b010);
    send(2'd2, 2'd0, "R5 oldest");
    send(2'd1, 2'd0, "R5 newest");
    wsts(32'h0001_0101);
    order_sel = 1'b0;
  endtask

  task automatic t_noretry();
    no_retry = 1'b1;
    load(2'd1, 32'h0040_0000, 4'd1, 32'd0, 32'd0);
    send(2'd1, 2'd2, "R8 setup");
    chk("R8 flags", sts[11:8], 4'b1001);
    chk("R8 empty", sts[27], 1);
    quiet("R8 no retry");
    no_retry = 1'b0;
    wsts(32'h0000_0100);
  endtask

  task automatic t_cancel_pend();
    load(2'd0, 32'h0040_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd0, "R9 lead");
    accept();
    load(2'd2, 32'h0020_0000, 4'd1, 32'd0, 32'd0);
    wsts(32'h0080_0000);
    chk("R9 flags", sts[19:16], 4'b0001);
    chk("R9 empty", sts[28], 1);
    result(2'd0);
    quiet("R9 not sent");
    wsts(32'h0001_0001);
  endtask

  task automatic t_cancel_flight();
    load(2'd1, 32'h0040_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd1, "R10 a");
    accept();
    wsts(32'h0000_8000);
    result(2'd1);
    chk("R10 lost flags", sts[11:8], 4'b0101);
    chk("R10 empty", sts[27], 1);
    quiet("R10 no retry");
    wsts(32'h0000_0100);
    load(2'd1, 32'h0040_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd1, "R10 b");
    accept();
    wsts(32'h0000_8000);
    result(2'd0);
    chk("R10 success wins", sts[11:8], 4'b0011);
    wsts(32'h0000_0100);
    load(2'd1, 32'h0040_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd1, "R10 c");
    accept();
    sts_we = 1'b1; sts_wdata = 32'h0000_8000;
    res_valid = 1'b1; res_code = 2'd1;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = '0; res_valid = 1'b0;
    chk("R10 same cycle", sts[11:8], 4'b0101);
    quiet("R10 same cycle no retry");
    wsts(32'h0000_0100);
  endtask

  task automatic t_clear_race();
    load(2'd0, 32'h0040_0000, 4'd1, 32'd0, 32'd0);
    wait_offer(2'd0, "R11 race");
    accept();
    sts_we = 1'b1; sts_wdata = 32'h0000_0001;
    res_valid = 1'b1; res_code = 2'd0;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = '0; res_valid = 1'b0;
    chk("R11 set wins", sts[3:0], 4'b0011);
    wsts(32'h0000_0001);
    chk("R1 idle again", sts, 32'h1C00_0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_len();
    t_idorder();
    t_ageorder();
    t_noretry();
    t_cancel_pend();
    t_cancel_flight();
    t_clear_race();
    finish_run();
  end
endmodule